// File: doc/BRIEF.md
# Key Search Control and Register Interface

This block is the control core of an exhaustive key search engine. An external cipher pipeline, which is not part of this block, produces one result word and the key behind it on every clock. The block compares each result word with a stored 64-bit target ciphertext. It keeps a copy of the most recent key to come out of the pipeline, and it halts the search when a result matches. A byte-wide processor port loads the plaintext and the target, passes key-counter bytes on to the external key stepper, and reads back the captured key and the run flag.

The run control is a two-state machine:
- `RS_STOP`: the stop flag is 1.
- `RS_GO`: the stop flag is 0.

It has three transitions:
- GO_CMD (`RS_STOP` to `RS_GO`): the processor writes 0 to the flag.
- HIT (`RS_GO` to `RS_STOP`): a result matches the target.
- HALT_CMD (`RS_GO` to `RS_STOP`): the processor writes 1 to the flag.

A flag write in the same cycle as a match takes priority over the match.

In use, the processor first stops the engine. It then loads the plaintext, the target and the starting key, and writes go. After that it polls the flag until the engine reports stop, and reads out the captured key.

Top module: `key_search_ctrl`

## Requirements
- R1: A synchronous reset puts the engine in `RS_STOP`. After reset the flag reads 1, the captured key reads 0, `plain_out` is 0 and `step_en` is 0.
- R2: A write with `sel`=1 and `rw`=0 to offsets 0..7 sets one plaintext byte. Offset n sets bits 8n+7..8n of `plain_out`, and the other seven bytes keep their values.
- R3: Writes to offsets 8..15 set the target ciphertext bytes with the same byte ordering, one byte per write.
- R4: A match requires all 64 bits of `pipe_result` to equal the target. A result that differs in any single bit leaves the engine in `RS_GO`.
- R5: In `RS_GO` the captured key loads `pipe_key` on every clock, whether or not the result matched. Reads (`rw`=1) at offsets 16..22 return captured-key bits 8n+7..8n for offset 16+n.
- R6: A match in `RS_GO` enters `RS_STOP` at that clock edge (transition HIT). The captured key then holds the key that produced the match.
- R7: A write to offset 24 loads data bit 0 into the flag (1 = stop, 0 = go). When a match occurs in the same cycle, the write decides the next state.
- R8: In `RS_STOP` the captured key does not change while `pipe_key` changes, and `step_en` is 0. In `RS_GO`, `step_en` is 1. After HALT_CMD the captured key holds the last key that emerged before the stop.
- R9: A write to offset 16+n (n = 0..6) while in `RS_STOP` raises only bit n of `key_we` for that cycle and presents the data on `key_wdata`. In `RS_GO` such a write raises no bit of `key_we`.
- R10: A read at offset 24 returns the flag in bit 0 with zeros above it. Reads of unmapped offsets (23, 25..31) return 0.
- R11: Writes to unmapped offsets change neither the plaintext, the flag nor `key_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Chip enable for the processor port |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when no read is in progress |
| pipe_result | input | 64 | Result word leaving the cipher pipeline |
| pipe_key | input | 56 | Key that produced `pipe_result` |
| plain_out | output | 64 | Plaintext supplied to the pipeline |
| step_en | output | 1 | Enables the external key stepper (high in `RS_GO`) |
| key_we | output | 7 | One-hot byte write strobes for the external key counter |
| key_wdata | output | 8 | Byte for the external key counter |

## Verification
The comparator is driven with the exact target and with copies that differ in one bit at the low end, in the middle and at the top. This shows whether every slice of the compare takes part in the match.

Captured-key reads are taken at three points: while running, after a HIT, and after a HALT_CMD. These separate "loads every cycle" from "loads only on a match" and from "keeps loading after stop".

A flag write issued in the same cycle as a matching result distinguishes the write-first priority from match-first. Single-byte overwrites and writes to unmapped offsets show whether the byte decode touches neighbouring bytes.

// File: rtl/kse_pkg.sv
package kse_pkg;

    typedef enum logic {
        RS_STOP = 1'b0,
        RS_GO   = 1'b1
    } run_state_e;

    localparam int PT_BASE   = 0;
    localparam int CT_BASE   = 8;
    localparam int KEY_BASE  = 16;
    localparam int FLAG_ADDR = 24;

endpackage

// File: rtl/kse_byte_reg.sv
module kse_byte_reg #(
    parameter int BYTES = 8,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       wd,
    output logic [BYTES*BYTE_W-1:0] q
);

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                byte_q <= wd;
            end
        end
        assign q[g*BYTE_W +: BYTE_W] = byte_q;
    end

endmodule

// File: rtl/kse_compare.sv
module kse_compare #(
    parameter int W = 64,
    parameter int SLICE = 16,
    localparam int NS = W / SLICE
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         equal
);

    logic [NS-1:0] slice_diff;

    for (genvar s = 0; s < NS; s++) begin : g_slice
        assign slice_diff[s] = |(a[s*SLICE +: SLICE] ^ b[s*SLICE +: SLICE]);
    end

    assign equal = ~|slice_diff;

endmodule

// File: rtl/kse_run_ctrl.sv
module kse_run_ctrl
    import kse_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flag_we,
    input  logic flag_wd,
    input  logic match,
    output logic stop_flag,
    output logic running
);

    run_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RS_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_STOP: begin
                if (flag_we && !flag_wd) begin
                    state_d = RS_GO;        // GO_CMD
                end
            end
            RS_GO: begin
                if (flag_we) begin
                    state_d = flag_wd ? RS_STOP : RS_GO;  // HALT_CMD, write wins
                end else if (match) begin
                    state_d = RS_STOP;      // HIT
                end
            end
            default: state_d = RS_STOP;
        endcase
    end

    always_comb begin
        stop_flag = (state_q == RS_STOP);
        running   = (state_q == RS_GO);
    end

    assert_hit_stops_R6: assert property (@(posedge clk) disable iff (rst)
        (running && match && !flag_we) |=> stop_flag);

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (rst)
        flag_we |=> (stop_flag == $past(flag_wd)));

    assert_stop_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_flag && !flag_we) |=> stop_flag);

endmodule

// File: rtl/key_search_ctrl.sv
module key_search_ctrl
    import kse_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int ADDR_W  = 5,
    parameter int BLOCK_W = 64,
    parameter int KEY_W   = 56,
    parameter int SLICE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [BLOCK_W-1:0]    pipe_result,
    input  logic [KEY_W-1:0]      pipe_key,
    output logic [BLOCK_W-1:0]    plain_out,
    output logic                  step_en,
    output logic [KEY_W/BYTE_W-1:0] key_we,
    output logic [BYTE_W-1:0]     key_wdata
);

    localparam int BLK_BYTES = BLOCK_W / BYTE_W;
    localparam int KEY_BYTES = KEY_W / BYTE_W;
    localparam int BIDX_W    = $clog2(BLK_BYTES);
    localparam logic [ADDR_W-1:0] PT_LO   = ADDR_W'(PT_BASE);
    localparam logic [ADDR_W-1:0] CT_LO   = ADDR_W'(CT_BASE);
    localparam logic [ADDR_W-1:0] KEY_LO  = ADDR_W'(KEY_BASE);
    localparam logic [ADDR_W-1:0] FLAG_AD = ADDR_W'(FLAG_ADDR);

    logic wr_stb, rd_stb;
    logic pt_hit, ct_hit, flag_we;
    logic [ADDR_W-1:0] pt_off, ct_off;
    logic [BLOCK_W-1:0] ct_q;
    logic match, stop_flag, running;
    logic [KEY_W-1:0] cap_key;

    assign wr_stb = sel && !rw;
    assign rd_stb = sel && rw;
    assign pt_off = addr - PT_LO;
    assign ct_off = addr - CT_LO;
    assign pt_hit = wr_stb && (addr >= PT_LO) && (addr < PT_LO + ADDR_W'(BLK_BYTES));
    assign ct_hit = wr_stb && (addr >= CT_LO) && (addr < CT_LO + ADDR_W'(BLK_BYTES));
    assign flag_we = wr_stb && (addr == FLAG_AD);

    kse_byte_reg #(.BYTES(BLK_BYTES), .BYTE_W(BYTE_W)) i_pt_reg (
        .clk (clk),
        .rst (rst),
        .we  (pt_hit),
        .idx (pt_off[BIDX_W-1:0]),
        .wd  (wdata),
        .q   (plain_out)
    );

    kse_byte_reg #(.BYTES(BLK_BYTES), .BYTE_W(BYTE_W)) i_ct_reg (
        .clk (clk),
        .rst (rst),
        .we  (ct_hit),
        .idx (ct_off[BIDX_W-1:0]),
        .wd  (wdata),
        .q   (ct_q)
    );

    kse_compare #(.W(BLOCK_W), .SLICE(SLICE_W)) i_cmp (
        .a     (pipe_result),
        .b     (ct_q),
        .equal (match)
    );

    kse_run_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flag_we   (flag_we),
        .flag_wd   (wdata[0]),
        .match     (match),
        .stop_flag (stop_flag),
        .running   (running)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_key <= '0;
        end else if (running) begin
            cap_key <= pipe_key;
        end
    end

    assign step_en   = running;
    assign key_wdata = wdata;

    for (genvar k = 0; k < KEY_BYTES; k++) begin : g_key_we
        assign key_we[k] = wr_stb && stop_flag && (addr == KEY_LO + ADDR_W'(k));
    end

    always_comb begin
        rdata = '0;
        if (rd_stb) begin
            if (addr == FLAG_AD) begin
                rdata = {{(BYTE_W-1){1'b0}}, stop_flag};
            end
            for (int i = 0; i < KEY_BYTES; i++) begin
                if (addr == KEY_LO + ADDR_W'(i)) begin
                    rdata = cap_key[i*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    assert_cap_follows_R5: assert property (@(posedge clk) disable iff (rst)
        step_en |=> (cap_key == $past(pipe_key)));

    assert_cap_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(cap_key));

    assert_key_we_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(key_we));

    assert_key_we_stopped_R9: assert property (@(posedge clk) disable iff (rst)
        (key_we != '0) |-> !step_en);

endmodule

// File: tb/test_key_search_ctrl.sv
module test_key_search_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        rw  = 1'b1;
    logic [4:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [63:0] pipe_result = 64'hFFFF_FFFF_FFFF_FFFF;
    logic [55:0] pipe_key = '0;
    logic [63:0] plain_out;
    logic        step_en;
    logic [6:0]  key_we;
    logic [7:0]  key_wdata;

    int total = 0;
    int bad = 0;

    localparam logic [63:0] CT = 64'hC3A5_1E7F_6B29_D480;
    localparam logic [63:0] PT = 64'h5D17_0E9C_B243_8AF6;

    always #2 clk = ~clk;

    key_search_ctrl i_key_search_ctrl (
        .clk (clk), .rst (rst), .sel (sel), .rw (rw), .addr (addr),
        .wdata (wdata), .rdata (rdata), .pipe_result (pipe_result),
        .pipe_key (pipe_key), .plain_out (plain_out), .step_en (step_en),
        .key_we (key_we), .key_wdata (key_wdata)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rw = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rw = 1'b1; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic read_cap(output logic [55:0] k);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            bus_read(5'(16 + i), b);
            k[i*8 +: 8] = b;
        end
    endtask

    task automatic read_flag(output logic f);
        logic [7:0] b;
        bus_read(5'd24, b);
        f = b[0];
    endtask

    task automatic t_reset();
        logic [55:0] k;
        logic [7:0] b;
        bus_read(5'd24, b);
        chk("R1 flag after reset", 64'(b), 64'h01);
        read_cap(k);
        chk("R1 captured key after reset", 64'(k), 64'h0);
        chk("R1 plain_out after reset", plain_out, 64'h0);
        chk("R1 step_en after reset", 64'(step_en), 64'h0);
    endtask

    task automatic t_plain();
        logic [63:0] exp;
        for (int i = 0; i < 8; i++) bus_write(5'(i), PT[i*8 +: 8]);
        chk("R2 plaintext full load", plain_out, PT);
        bus_write(5'd5, 8'h3C);
        exp = PT;
        exp[47:40] = 8'h3C;
        chk("R2 single byte overwrite", plain_out, exp);
        bus_write(5'd5, PT[47:40]);
        chk("R2 byte restored", plain_out, PT);
    endtask

    task automatic t_match();
        logic [55:0] k;
        logic f;
        for (int i = 0; i < 8; i++) bus_write(5'(8 + i), CT[i*8 +: 8]);
        pipe_result = ~CT;
        bus_write(5'd24, 8'h00);
        chk("R8 step_en in go", 64'(step_en), 64'h1);
        @(negedge clk);
        pipe_key = 56'h9A_0B7C_33E1_4D62;
        read_cap(k);
        chk("R5 captured key follows pipeline", 64'(k), 64'h009A_0B7C_33E1_4D62);
        @(negedge clk);
        pipe_key = 56'h11_2233_4455_6677;
        read_cap(k);
        chk("R5 captured key second value", 64'(k), 64'h0011_2233_4455_6677);
        @(negedge clk);
        pipe_result = CT;
        pipe_key = 56'hE4_D2C1_0F9B_8A57;
        @(negedge clk);
        pipe_result = ~CT;
        pipe_key = 56'h00_0000_0000_0001;
        read_flag(f);
        chk("R3 R6 match stops engine", 64'(f), 64'h1);
        chk("R8 step_en in stop", 64'(step_en), 64'h0);
        read_cap(k);
        chk("R6 captured matching key", 64'(k), 64'h00E4_D2C1_0F9B_8A57);
        pipe_key = 56'h77_7777_7777_7777;
        repeat (3) @(negedge clk);
        read_cap(k);
        chk("R8 captured key frozen in stop", 64'(k), 64'h00E4_D2C1_0F9B_8A57);
    endtask

    task automatic t_nearmiss();
        logic f;
        int bits [4] = '{0, 17, 40, 63};
        bus_write(5'd24, 8'h00);
        foreach (bits[j]) begin
            @(negedge clk);
            pipe_result = CT ^ (64'h1 << bits[j]);
            @(negedge clk);
            pipe_result = ~CT;
            read_flag(f);
            chk($sformatf("R4 one-bit miss at bit %0d", bits[j]), 64'(f), 64'h0);
        end
    endtask

    task automatic t_override();
        logic f;
        logic [55:0] k;
        @(negedge clk);
        pipe_result = CT;
        sel = 1'b1; rw = 1'b0; addr = 5'd24; wdata = 8'h00;
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
        pipe_result = ~CT;
        read_flag(f);
        chk("R7 go write beats same-cycle match", 64'(f), 64'h0);
        @(negedge clk);
        pipe_key = 56'h5A_5A5A_A5A5_3C3C;
        sel = 1'b1; rw = 1'b0; addr = 5'd24; wdata = 8'h01;
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
        pipe_key = 56'h01_0203_0405_0607;
        read_flag(f);
        chk("R7 halt write stops engine", 64'(f), 64'h1);
        read_cap(k);
        chk("R8 captured key holds last key before halt", 64'(k), 64'h005A_5A5A_A5A5_3C3C);
    endtask

    task automatic t_keywr();
        @(negedge clk);
        sel = 1'b1; rw = 1'b0; addr = 5'd18; wdata = 8'hA5;
        #1;
        chk("R9 key strobe in stop", 64'(key_we), 64'h04);
        chk("R9 key data", 64'(key_wdata), 64'hA5);
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
        #1;
        chk("R9 key strobe ends", 64'(key_we), 64'h0);
        bus_write(5'd24, 8'h00);
        @(negedge clk);
        sel = 1'b1; rw = 1'b0; addr = 5'd18; wdata = 8'hA5;
        #1;
        chk("R9 no key strobe in go", 64'(key_we), 64'h0);
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
        bus_write(5'd24, 8'h01);
    endtask

    task automatic t_unmapped();
        logic [7:0] b;
        logic f;
        bus_read(5'd23, b);
        chk("R10 read offset 23", 64'(b), 64'h0);
        bus_read(5'd25, b);
        chk("R10 read offset 25", 64'(b), 64'h0);
        bus_read(5'd31, b);
        chk("R10 read offset 31", 64'(b), 64'h0);
        bus_read(5'd24, b);
        chk("R10 flag read upper bits zero", 64'(b), 64'h01);
        @(negedge clk);
        sel = 1'b1; rw = 1'b0; addr = 5'd23; wdata = 8'hFF;
        #1;
        chk("R11 no key strobe at offset 23", 64'(key_we), 64'h0);
        @(negedge clk);
        sel = 1'b0; rw = 1'b1;
        bus_write(5'd25, 8'h00);
        bus_write(5'd31, 8'hFF);
        chk("R11 plaintext untouched", plain_out, PT);
        read_flag(f);
        chk("R11 flag untouched", 64'(f), 64'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_match();
        t_nearmiss();
        t_override();
        t_keywr();
        t_unmapped();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule